// File: doc/BRIEF.md
# Busy-Interval Duty Meter

This block measures how long a periodically asserted busy flag stays high, as a fraction of its repetition period. The flag is typically the top bit of a status register in a slow peripheral that updates its registers once per second. Software or a polling engine samples that bit and presents the sampled level on `busy_i`. A free-running cycle counter provides timestamps.

After `start_i` is accepted, the meter waits until the flag is low, so an interval already under way is never measured. It then stamps the next rising level, the falling level that follows and the rising level after that. From these stamps it derives the high time and the full period. A sequential restoring divider turns the pair into an unsigned Q0.16 fraction. The raw counts, the fraction and a one-cycle completion pulse appear together. A programmable limit abandons a measurement whose awaited level never arrives.

Top module: `duty_meter`

## Requirements
- R1: After reset, `done_o` and `timeout_o` are 0 and `busy_cnt_o`, `period_cnt_o` and `ratio_o` are all 0.
- R2: A measurement starts only from a sampled low level of `busy_i`. If the flag is high when `start_i` is accepted, that interval is skipped and the first timestamp is taken at the next low-to-high change.
- R3: `busy_cnt_o` equals the number of clock edges from the first edge sampling `busy_i` high to the first later edge sampling it low.
- R4: `period_cnt_o` equals the number of clock edges from that first high sample to the next high sample that follows the low phase.
- R5: `ratio_o` equals floor(`busy_cnt_o` * 65536 / `period_cnt_o`), read as an unsigned fraction with bit 15 worth one half.
- R6: `done_o` is high for exactly one cycle per completed measurement, and the counts and ratio are valid in that cycle. They hold their values until the next measurement completes.
- R7: With `limit_i` nonzero, if `limit_i` consecutive edges in one waiting phase pass without the awaited level, `timeout_o` pulses for one cycle and the measurement is abandoned with outputs unchanged. `limit_i` = 0 disables the limit.
- R8: `start_i` is ignored while a measurement or division is in progress.
- R9: `done_o` and `timeout_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arm a measurement (accepted only when idle) |
| busy_i | input | 1 | Sampled busy flag of the monitored peripheral |
| limit_i | input | LIM_W | Edges allowed per waiting phase; 0 disables |
| done_o | output | 1 | One-cycle result-valid pulse |
| timeout_o | output | 1 | One-cycle abandoned-measurement pulse |
| busy_cnt_o | output | CNT_W | High time in cycles |
| period_cnt_o | output | CNT_W | Full period in cycles |
| ratio_o | output | FRAC_W | High time over period, unsigned fraction |

## Verification
The hardest case to reach is a flag that is already high when the meter is armed. A careless design would stamp that partial interval, and the outcome differs only in the counts. The bench arms the meter with the flag held high for several edges before the low phase, then checks that the counts match the later full interval. The exact timeout window is another edge-counting case. The bench holds the awaited level away and counts edges from acceptance of the start to the error pulse, then shows that a zero limit lets the meter wait indefinitely and still complete a later measurement.

// File: rtl/duty_meter_pkg.sv
package duty_meter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LOW,
    ST_WAIT_RISE,
    ST_WAIT_FALL,
    ST_WAIT_NEXT,
    ST_DIVIDE
  } dm_state_e;
endpackage

// File: rtl/duty_meter_tsc.sv
module duty_meter_tsc #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/duty_meter_seq.sv
module duty_meter_seq
  import duty_meter_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic [CNT_W-1:0] ts_i,
  input  logic             div_done_i,
  output logic             launch_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] busy_cnt_o,
  output logic [CNT_W-1:0] period_cnt_o
);
  dm_state_e        state_q;
  logic [CNT_W-1:0] t_rise_q, t_fall_q;
  logic [LIM_W-1:0] wdog_q;
  logic             waiting, want_high, hit, expire;

  always_comb begin
    waiting   = (state_q == ST_WAIT_LOW)  || (state_q == ST_WAIT_RISE) ||
                (state_q == ST_WAIT_FALL) || (state_q == ST_WAIT_NEXT);
    want_high = (state_q == ST_WAIT_RISE) || (state_q == ST_WAIT_NEXT);
    hit       = waiting && (busy_i == want_high);
    // wdog_q counts edges already spent in this phase without a hit
    expire    = waiting && !hit && (limit_i != '0) &&
                (({1'b0, wdog_q} + 1'b1) == {1'b0, limit_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      t_rise_q     <= '0;
      t_fall_q     <= '0;
      wdog_q       <= '0;
      launch_o     <= 1'b0;
      timeout_o    <= 1'b0;
      busy_cnt_o   <= '0;
      period_cnt_o <= '0;
    end else begin
      launch_o  <= 1'b0;
      timeout_o <= 1'b0;
      wdog_q    <= (waiting && !hit) ? wdog_q + 1'b1 : '0;
      if (expire) begin
        state_q   <= ST_IDLE;
        timeout_o <= 1'b1;
        wdog_q    <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE:      if (start_i) state_q <= ST_WAIT_LOW;
          ST_WAIT_LOW:  if (hit) state_q <= ST_WAIT_RISE;
          ST_WAIT_RISE: if (hit) begin
            t_rise_q <= ts_i;
            state_q  <= ST_WAIT_FALL;
          end
          ST_WAIT_FALL: if (hit) begin
            t_fall_q <= ts_i;
            state_q  <= ST_WAIT_NEXT;
          end
          ST_WAIT_NEXT: if (hit) begin
            busy_cnt_o   <= t_fall_q - t_rise_q;
            period_cnt_o <= ts_i - t_rise_q;
            launch_o     <= 1'b1;
            state_q      <= ST_DIVIDE;
          end
          ST_DIVIDE:    if (div_done_i) state_q <= ST_IDLE;
          default:      state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/duty_meter_div.sv
module duty_meter_div #(
  parameter int NUM_W = 32,
  parameter int Q_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [NUM_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int CB = $clog2(Q_W + 1);

  logic [NUM_W:0]   rem_q, shifted;
  logic [NUM_W-1:0] den_q;
  logic [Q_W-1:0]   acc_q;
  logic [CB-1:0]    cnt_q;
  logic             ge;

  always_comb begin
    shifted = {rem_q[NUM_W-1:0], 1'b0};
    ge      = shifted >= {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= {1'b0, num_i};  // num < den, so every step fits
        den_q <= den_i;
        acc_q <= '0;
        cnt_q <= CB'(Q_W);
      end else if (cnt_q != '0) begin
        rem_q <= ge ? shifted - {1'b0, den_q} : shifted;
        acc_q <= {acc_q[Q_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CB'(1)) begin
          quo_o  <= {acc_q[Q_W-2:0], ge};
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/duty_meter.sv
module duty_meter #(
  parameter int CNT_W  = 32,
  parameter int LIM_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  busy_cnt_o,
  output logic [CNT_W-1:0]  period_cnt_o,
  output logic [FRAC_W-1:0] ratio_o
);
  logic [CNT_W-1:0] ts;
  logic             launch;

  duty_meter_tsc #(.CNT_W(CNT_W)) u_tsc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts)
  );

  duty_meter_seq #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_i      (busy_i),
    .limit_i     (limit_i),
    .ts_i        (ts),
    .div_done_i  (done_o),
    .launch_o    (launch),
    .timeout_o   (timeout_o),
    .busy_cnt_o  (busy_cnt_o),
    .period_cnt_o(period_cnt_o)
  );

  duty_meter_div #(.NUM_W(CNT_W), .Q_W(FRAC_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch),
    .num_i  (busy_cnt_o),
    .den_i  (period_cnt_o),
    .done_o (done_o),
    .quo_o  (ratio_o)
  );
endmodule

// File: rtl/duty_meter_chk.sv
module duty_meter_chk #(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              timeout_o,
  input logic [CNT_W-1:0]  busy_cnt_o,
  input logic [CNT_W-1:0]  period_cnt_o,
  input logic [FRAC_W-1:0] ratio_o
);
  localparam int PW = CNT_W + FRAC_W + 2;
  logic [PW-1:0] p_lo, p_hi, scaled;

  always_comb begin
    p_lo   = PW'(ratio_o) * PW'(period_cnt_o);
    p_hi   = (PW'(ratio_o) + PW'(1)) * PW'(period_cnt_o);
    scaled = PW'(busy_cnt_o) << FRAC_W;
  end

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_timeout_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  a_r4_period_exceeds_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (period_cnt_o > busy_cnt_o) && (busy_cnt_o != '0));
  a_r5_ratio_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (p_lo <= scaled) && (p_hi > scaled));
  a_r7_timeout_keeps_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $stable(busy_cnt_o) && $stable(period_cnt_o) && $stable(ratio_o));
endmodule

bind duty_meter duty_meter_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .busy_cnt_o  (busy_cnt_o),
  .period_cnt_o(period_cnt_o),
  .ratio_o     (ratio_o)
);

// File: tb/duty_meter_bench.sv
module duty_meter_bench;
  localparam int CNT_W = 32, LIM_W = 16, FRAC_W = 16;
  localparam int NV = 8;
  // {skip_high[49], mid_start[48], pre[47:32], high[31:16], low[15:0]}
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd2, 16'd1,  16'd1},
    {1'b0, 1'b0, 16'd1, 16'd3,  16'd1},
    {1'b0, 1'b0, 16'd3, 16'd1,  16'd3},
    {1'b0, 1'b0, 16'd2, 16'd5,  16'd2},
    {1'b0, 1'b0, 16'd1, 16'd1,  16'd9},
    {1'b0, 1'b0, 16'd4, 16'd20, 16'd7},
    {1'b1, 1'b0, 16'd1, 16'd2,  16'd1},
    {1'b0, 1'b1, 16'd2, 16'd4,  16'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, busy = 1'b0;
  logic [LIM_W-1:0]  limit = '0;
  logic              done, tmo;
  logic [CNT_W-1:0]  bcnt, pcnt;
  logic [FRAC_W-1:0] ratio;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  duty_meter u_duty_meter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_i(busy),
    .limit_i(limit), .done_o(done), .timeout_o(tmo),
    .busy_cnt_o(bcnt), .period_cnt_o(pcnt), .ratio_o(ratio)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_meas(input int pre, input int hi, input int lo,
                          input bit skip_high, input bit mid_start);
    bit got;
    longint exp_r;
    @(negedge clk); busy = skip_high; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (skip_high) repeat (2) @(negedge clk);
    busy = 1'b0; repeat (pre) @(negedge clk);
    busy = 1'b1; if (mid_start) start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (hi - 1) @(negedge clk);
    busy = 1'b0; repeat (lo) @(negedge clk);
    busy = 1'b1;
    got = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      chk(!tmo, "R7 no timeout in valid run", tmo, 0);
      if (done) begin got = 1; break; end
    end
    exp_r = (longint'(hi) << 16) / (hi + lo);
    chk(got, "R6 done seen", got, 1);
    chk(bcnt == CNT_W'(hi), skip_high ? "R2/R3 busy count after skip" : "R3 busy count",
        bcnt, hi);
    chk(pcnt == CNT_W'(hi + lo), mid_start ? "R8/R4 period with mid start" : "R4 period",
        pcnt, hi + lo);
    chk(ratio == FRAC_W'(exp_r), "R5 ratio", ratio, exp_r);
    @(posedge clk); #1;
    chk(!done, "R6 done one cycle", done, 0);
    chk(bcnt == CNT_W'(hi), "R6 busy count held", bcnt, hi);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [CNT_W-1:0] sv_b, sv_p;
    logic [FRAC_W-1:0] sv_r;
    repeat (3) @(negedge clk);
    chk(!done && !tmo, "R1 reset pulses", {done, tmo}, 0);
    chk(bcnt == 0 && pcnt == 0 && ratio == 0, "R1 reset outputs", bcnt + pcnt + ratio, 0);
    rst_n = 1'b1;
    limit = 16'd1000;
    for (int v = 0; v < NV; v++)
      run_meas(int'(VEC[v][47:32]), int'(VEC[v][31:16]), int'(VEC[v][15:0]),
               VEC[v][49], VEC[v][48]);

    // R7: exact window in the wait-for-low phase
    sv_b = bcnt; sv_p = pcnt; sv_r = ratio;
    limit = 16'd5;
    @(negedge clk); busy = 1'b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); n++; #1;
      chk(!done, "R9 no done while timing out", done, 0);
      if (tmo) break;
    end
    chk(n == 5, "R7 timeout edge count", n, 5);
    @(posedge clk); #1;
    chk(!tmo, "R7 timeout one cycle", tmo, 0);
    chk(bcnt == sv_b && pcnt == sv_p && ratio == sv_r, "R7 outputs unchanged", bcnt, sv_b);

    // R7: timeout in the wait-for-fall phase
    limit = 16'd7;
    @(negedge clk); busy = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); busy = 1'b1;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (tmo) begin n = 1; break; end
    end
    chk(n == 1, "R7 timeout while high", n, 1);

    // R7: limit zero never times out, then completes
    limit = '0;
    @(negedge clk); busy = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      if (tmo) n++;
    end
    chk(n == 0, "R7 limit zero disables", n, 0);
    run_meas(2, 6, 3, 1'b0, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule